// File: doc/BRIEF.md
# Scanline Interrupt and Beam Bit Sampler

This block watches the scanline and horizontal position reported by a video timing generator and raises a level interrupt to the CPU at fixed scanlines, spaced 64 lines apart. Once reset, the first interrupt comes on line 0. From then on the slots repeat as 64, 128, 192 and 256, after which the sequence returns to 64 rather than 0. The interrupt is held high until the horizontal blank of the line that raised it begins.

Alongside the interrupt, the block serialises a light-gun beam position to the CPU. At the slot on line 64, which is the first slot after vertical blank, it latches an X and a Y coordinate of 8 bits each. At every slot from 64 to 256 it then publishes a 4-bit nibble that carries two bits of each axis. Across the four slots of a frame the CPU therefore collects all eight bits of both coordinates.

Top module: `raster_irq_sampler`

## Requirements
- R1: `irq` rises only on the clock edge that first samples a scanline equal to the pending slot. Every slot line is a multiple of 64, and the first slot after reset is line 0.
- R2: The slot after line 256 is line 64, so line 0 and the lines from 257 upward never raise an interrupt once the first slot has passed.
- R3: `irq` stays high, including while the position inputs are frozen, and falls on the clock edge that samples `scan_hpos == HBLANK_START` on the line that raised it. It also falls if the scanline changes first.
- R4: `gun_x` and `gun_y` are captured only at the line-64 slot, using the values present on that edge. Their values on every other line have no effect on the nibbles that follow.
- R5: `beam_nibble` changes only on the edge on which `irq` rises at a slot of line 64 or above. At the line-0 slot it keeps its value.
- R6: At a slot on line L, let k = (L-64)/64, taking values 0 to 3. Each latched coordinate is shifted left by k and truncated to 8 bits. The nibble is then {X'[7], X'[3], Y'[7], Y'[3]}, with bit 3 first, which equals {X[7-k], X[3-k], Y[7-k], Y[3-k]}.
- R7: One slot raises exactly one interrupt. Repeating or holding the slot scanline never raises `irq` a second time.
- R8: While `rst_n` is low, `irq` is 0 and `beam_nibble` is 0, and the pending slot returns to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_line | input | LINE_W | Current scanline from the timing generator |
| scan_hpos | input | HPOS_W | Current horizontal position |
| gun_x | input | COORD_W | Beam X coordinate from the gun sensing logic |
| gun_y | input | COORD_W | Beam Y coordinate from the gun sensing logic |
| irq | output | 1 | Level interrupt to the CPU |
| beam_nibble | output | 4 | Serialised beam bits for the CPU to read |

## Verification
The assertions assume that `scan_line` moves forward one line at a time and never jumps onto the next slot in the cycle right after `irq` falls. They also assume that `scan_hpos` passes through `HBLANK_START` on each slot line. The bench models a raster with 262 lines of 32 positions each, with horizontal blank at position 24. It changes the gun inputs on every line, freezes `scan_hpos` for 80 cycles on one slot line, and repeats a whole slot line. None of this stimulus breaks those assumptions, so any spurious interrupt or mis-timed fall is a design fault and not a stimulus artefact.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int COORD_W = 8;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } beam_pair_t;

  // Next slot in the interrupt sequence, wrapping from the last slot back
  function automatic int advance_slot(input int cur, input int spacing,
                                      input int last, input int wrap);
    if (cur >= last) return wrap;
    return cur + spacing;
  endfunction

  // Shift both coordinates by k (truncated to COORD_W) and pick the top bit
  // of each half of each coordinate
  function automatic logic [3:0] beam_bits(input beam_pair_t p, input logic [2:0] k);
    logic [COORD_W-1:0] sx;
    logic [COORD_W-1:0] sy;
    sx = p.x << k;
    sy = p.y << k;
    return {sx[COORD_W-1], sx[COORD_W/2-1], sy[COORD_W-1], sy[COORD_W/2-1]};
  endfunction

endpackage

// File: rtl/irq_slot_sequencer.sv
module irq_slot_sequencer #(
  parameter int LINE_W     = 9,
  parameter int SPACING    = 64,
  parameter int FIRST_SLOT = 0,
  parameter int LAST_SLOT  = 256,
  parameter int WRAP_SLOT  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] scan_line,
  output logic              fire,
  output logic              capture_evt,
  output logic              shift_evt,
  output logic [2:0]        shift_k
);
  localparam int SLOT_LSB = $clog2(SPACING);

  logic [LINE_W-1:0] next_slot;
  logic [LINE_W-1:0] line_off;

  assign fire        = (scan_line == next_slot);
  assign capture_evt = fire && (next_slot == LINE_W'(WRAP_SLOT));
  assign shift_evt   = fire && (scan_line >= LINE_W'(WRAP_SLOT));
  assign line_off    = scan_line - LINE_W'(WRAP_SLOT);
  assign shift_k     = 3'(line_off >> SLOT_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_slot <= LINE_W'(FIRST_SLOT);
    end else if (fire) begin
      next_slot <= LINE_W'(rsb_pkg::advance_slot(int'(next_slot), SPACING,
                                                 LAST_SLOT, WRAP_SLOT));
    end
  end

  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (scan_line[SLOT_LSB-1:0] == '0)); // R1

endmodule

// File: rtl/irq_driver.sv
module irq_driver #(
  parameter int LINE_W       = 9,
  parameter int HPOS_W       = 9,
  parameter int HBLANK_START = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [HPOS_W-1:0] scan_hpos,
  output logic              irq,
  output logic              drop_evt
);
  logic [LINE_W-1:0] irq_line;

  // A new slot wins over a drop; otherwise drop at hblank or on a line change
  assign drop_evt = irq && !fire &&
                    ((scan_line != irq_line) || (scan_hpos == HPOS_W'(HBLANK_START)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_line <= '0;
    end else if (fire) begin
      irq      <= 1'b1;
      irq_line <= scan_line;
    end else if (drop_evt) begin
      irq <= 1'b0;
    end
  end

  AST_IRQ_DROP_AT_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fire && scan_hpos == HPOS_W'(HBLANK_START)) |=> !irq); // R3

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |=> !irq); // R7

endmodule

// File: rtl/beam_sampler.sv
module beam_sampler #(
  parameter int COORD_W = rsb_pkg::COORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_evt,
  input  logic               shift_evt,
  input  logic [2:0]         shift_k,
  input  logic [COORD_W-1:0] gun_x,
  input  logic [COORD_W-1:0] gun_y,
  output logic [3:0]         beam_nibble
);
  rsb_pkg::beam_pair_t latched;
  rsb_pkg::beam_pair_t source;

  // On the capture slot the fresh inputs feed the nibble directly
  always_comb begin
    if (capture_evt) begin
      source.x = gun_x;
      source.y = gun_y;
    end else begin
      source = latched;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched     <= '0;
      beam_nibble <= '0;
    end else begin
      if (capture_evt) latched <= source;
      if (shift_evt)   beam_nibble <= rsb_pkg::beam_bits(source, shift_k);
    end
  end

endmodule

// File: rtl/raster_irq_sampler.sv
module raster_irq_sampler #(
  parameter int LINE_W       = 9,
  parameter int HPOS_W       = 9,
  parameter int COORD_W      = rsb_pkg::COORD_W,
  parameter int SPACING      = 64,
  parameter int FIRST_SLOT   = 0,
  parameter int LAST_SLOT    = 256,
  parameter int WRAP_SLOT    = 64,
  parameter int HBLANK_START = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_W-1:0]  scan_line,
  input  logic [HPOS_W-1:0]  scan_hpos,
  input  logic [COORD_W-1:0] gun_x,
  input  logic [COORD_W-1:0] gun_y,
  output logic               irq,
  output logic [3:0]         beam_nibble
);
  logic       fire;
  logic       capture_evt;
  logic       shift_evt;
  logic [2:0] shift_k;
  logic       drop_evt;

  irq_slot_sequencer #(
    .LINE_W(LINE_W), .SPACING(SPACING), .FIRST_SLOT(FIRST_SLOT),
    .LAST_SLOT(LAST_SLOT), .WRAP_SLOT(WRAP_SLOT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_line(scan_line), .fire(fire),
    .capture_evt(capture_evt), .shift_evt(shift_evt), .shift_k(shift_k)
  );

  irq_driver #(
    .LINE_W(LINE_W), .HPOS_W(HPOS_W), .HBLANK_START(HBLANK_START)
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .scan_line(scan_line),
    .scan_hpos(scan_hpos), .irq(irq), .drop_evt(drop_evt)
  );

  beam_sampler #(.COORD_W(COORD_W)) u_beam (
    .clk(clk), .rst_n(rst_n), .capture_evt(capture_evt), .shift_evt(shift_evt),
    .shift_k(shift_k), .gun_x(gun_x), .gun_y(gun_y), .beam_nibble(beam_nibble)
  );

  AST_NIBBLE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(beam_nibble) |-> $rose(irq)); // R5

  AST_DROP_NOT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !irq); // R3

endmodule

// File: tb/sim_raster_irq_sampler.sv
module sim_raster_irq_sampler;
  localparam int LW = 9, HW = 9, HB = 24, HTOT = 32, LINES = 262;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] scan_line = LW'(300);
  logic [HW-1:0] scan_hpos = '0;
  logic [7:0] gun_x = '0, gun_y = '0;
  logic irq;
  logic [3:0] beam_nibble;

  always #10 clk = ~clk;

  raster_irq_sampler #(.LINE_W(LW), .HPOS_W(HW), .HBLANK_START(HB)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_line(scan_line), .scan_hpos(scan_hpos),
    .gun_x(gun_x), .gun_y(gun_y), .irq(irq), .beam_nibble(beam_nibble)
  );

  typedef struct { int line; logic [3:0] nib; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  int exp_next = 0;
  logic [7:0] cur_x = '0, cur_y = '0;
  logic [3:0] cur_nib = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] gx(input int fr, input int ln);
    return 8'((fr * 37 + ln * 11 + 5) & 255);
  endfunction
  function automatic logic [7:0] gy(input int fr, input int ln);
    return 8'((fr * 91 + ln * 29 + 77) & 255);
  endfunction
  // Nibble for slot index k: picks bit 7-k and 3-k of each axis (R6)
  function automatic logic [3:0] exp_nib(input logic [7:0] x, input logic [7:0] y, input int k);
    return {x[7-k], x[3-k], y[7-k], y[3-k]};
  endfunction

  // Driver: push the expected event, then drive one raster line
  task automatic drive_line(input int fr, input int ln, input int stall, input int reps);
    if (ln == exp_next) begin
      if (ln == 64) begin cur_x = gx(fr, 64); cur_y = gy(fr, 64); end
      if (ln >= 64) cur_nib = exp_nib(cur_x, cur_y, (ln - 64) / 64);
      q.push_back('{line: ln, nib: cur_nib});
      exp_next = (ln == 256) ? 64 : ln + 64;
    end
    for (int r = 0; r < reps; r++) begin
      for (int h = 0; h < HTOT; h++) begin
        @(posedge clk); #2;
        scan_line = LW'(ln); scan_hpos = HW'(h);
        gun_x = gx(fr, ln); gun_y = gy(fr, ln);
        if (h == 5 && stall > 0) begin
          repeat (stall) @(posedge clk);
          @(negedge clk);
          chk(irq == 1'b1, "R3 irq held while inputs frozen", int'(irq), 1);
        end
      end
    end
  endtask

  // Monitor: compare each rising irq against the scoreboard
  logic prev_irq = 1'b0;
  int line_prev = 0, hpos_prev = 0, rise_line = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !prev_irq) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7/R2 unexpected irq", line_prev, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(line_prev == e.line, "R1/R2 irq slot line", line_prev, e.line);
          chk(beam_nibble == e.nib, (e.line == 0) ? "R5 nibble kept at slot 0" : "R4/R6 nibble",
              int'(beam_nibble), int'(e.nib));
        end
        rise_line = line_prev;
      end
      if (!irq && prev_irq) begin
        chk(hpos_prev == HB, "R3 irq fall hpos", hpos_prev, HB);
        chk(line_prev == rise_line, "R3 irq fall line", line_prev, rise_line);
      end
    end
    prev_irq  <= irq;
    line_prev <= int'(scan_line);
    hpos_prev <= int'(scan_hpos);
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq in reset", int'(irq), 0);
    chk(beam_nibble == 4'd0, "R8 nibble in reset", int'(beam_nibble), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    // Frame 0: plain
    for (int ln = 0; ln < LINES; ln++) drive_line(0, ln, 0, 1);
    // Frame 1: freeze inputs on slot 128, repeat slot 192
    for (int ln = 0; ln < LINES; ln++)
      drive_line(1, ln, (ln == 128) ? 80 : 0, (ln == 192) ? 2 : 1);
    // Frame 2: plain
    for (int ln = 0; ln < LINES; ln++) drive_line(2, ln, 0, 1);
    // Mid-run reset
    @(posedge clk); #2; rst_n = 1'b0; scan_line = LW'(100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq after reset", int'(irq), 0);
    chk(beam_nibble == 4'd0, "R8 nibble after reset", int'(beam_nibble), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    exp_next = 0; cur_nib = '0; cur_x = '0; cur_y = '0;
    // Frame 3: sequence restarts at line 0
    for (int ln = 0; ln < LINES; ln++) drive_line(3, ln, 0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R7 all expected slots seen once", q.size(), 0);
    chk(irq == 1'b0, "R3 irq low at frame end", int'(irq), 0);
    done = 1;
    finish_run();
  end

endmodule